// File: doc/BRIEF.md
# Bit-Serial Adder-Subtractor with Parallel Operand Load

This block adds or subtracts two small unsigned operands one bit at a time, using a single full adder and a one-bit carry register. A start strobe copies both operands into internal shift registers in one clock. The block then runs one shift cycle per operand bit, beginning with the least significant bit. Each new sum bit enters the top of the first operand register while that register shifts right, so the result builds up in the register that held the first operand.

The second operand register rotates as it shifts, so it holds its loaded value again when the operation ends. If the mode input is high on the start cycle, the block stores the bitwise inverse of the second operand and presets the carry to one. This gives the two's complement difference. When the last bit has been processed a done flag rises, and the block then stays idle until the next start. Carries out of the top bit are discarded, so results wrap modulo 2^W.

Top module: `serial_addsub`

## Requirements
- R1: A synchronous reset clears `result` to 0 and `done` to 0.
- R2: On the clock edge where `start` is high, `result` takes the value of `opnd_a` and `done` goes to 0. This happens in that single edge, with no shift on that edge.
- R3: With `sub_mode` low at start, `result` equals (`opnd_a` + `opnd_b`) mod 16 after four further clock edges.
- R4: With `sub_mode` high at start, `result` equals (`opnd_a` - `opnd_b`) mod 16 after four further clock edges.
- R5: `done` stays 0 after the first, second and third shift edges and is 1 after the fourth.
- R6: While `done` is 1 and `start` is low, `result` and `done` do not change, whatever `opnd_a`, `opnd_b` and `sub_mode` do.
- R7: A start during a running operation abandons it. The new operands are captured, and the count of four shift cycles begins again from that edge.
- R8: Processing is LSB first. After k shift edges (k = 1..4), `result` equals the low k bits of the final answer placed in its top k bit positions, with `opnd_a` shifted right by k in the remaining low bits.
- R9: A carry out of bit 3 is dropped and not reported. For example, 15 + 1 gives 0, and 0 - 1 gives 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Parallel load strobe; begins a new operation |
| sub_mode | input | 1 | Sampled at start: 0 add, 1 subtract |
| opnd_a | input | 4 | First operand (minuend in subtract mode) |
| opnd_b | input | 4 | Second operand (subtrahend in subtract mode) |
| result | output | 4 | Operand A register, holding the result once done is high |
| done | output | 1 | High once four shift cycles have completed |

## Verification
The assertions assume that `opnd_a`, `opnd_b` and `sub_mode` matter only on edges where `start` is high. Reset is expected to be held from time zero through at least one edge. The stimulus changes operands and mode freely while an operation runs and while the block sits done, so that these cases exercise the idle hold. Random operations mix both modes across the full 4-bit range. Directed cases cover wrap-around and a restart in the middle of a run.

// File: rtl/serial_addsub.sv
module serial_addsub #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         sub_mode,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  output logic [W-1:0] result,
  output logic         done
);
  localparam int CW = $clog2(W) + 1;

  logic [W-1:0]  a_q, b_q;
  logic          cy_q, run_q, done_q;
  logic [CW-1:0] cnt_q;

  wire sum_bit = a_q[0] ^ b_q[0] ^ cy_q;
  wire cy_next = (a_q[0] & b_q[0]) | (cy_q & (a_q[0] ^ b_q[0]));
  wire last    = (cnt_q == CW'(W - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q    <= '0;
      b_q    <= '0;
      cy_q   <= 1'b0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (start) begin
      a_q    <= opnd_a;
      b_q    <= sub_mode ? ~opnd_b : opnd_b;
      cy_q   <= sub_mode;
      cnt_q  <= '0;
      run_q  <= 1'b1;
      done_q <= 1'b0;
    end else if (run_q) begin
      a_q    <= {sum_bit, a_q[W-1:1]};
      b_q    <= {b_q[0], b_q[W-1:1]};
      cy_q   <= cy_next;
      cnt_q  <= cnt_q + 1'b1;
      run_q  <= ~last;
      done_q <= last;
    end
  end

  assign result = a_q;
  assign done   = done_q;
endmodule

// File: rtl/serial_addsub_chk.sv
module serial_addsub_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         sub_mode,
  input logic [W-1:0] opnd_a,
  input logic [W-1:0] opnd_b,
  input logic [W-1:0] result,
  input logic         done
);
  localparam int CW = $clog2(W + 1) + 1;

  logic [CW-1:0] cnt_c;
  logic          vld_c;
  logic [W-1:0]  exp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_c <= '0;
      vld_c <= 1'b0;
      exp_q <= '0;
    end else if (start) begin
      cnt_c <= '0;
      vld_c <= 1'b1;
      exp_q <= sub_mode ? opnd_a - opnd_b : opnd_a + opnd_b;
    end else if (vld_c && cnt_c < CW'(W)) begin
      cnt_c <= cnt_c + 1'b1;
    end
  end

  p_reset_r1: assert property (@(posedge clk) rst |=> (result == '0 && !done));
  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    start |=> (result == $past(opnd_a) && !done));
  p_done_r5: assert property (@(posedge clk) disable iff (rst)
    done == (vld_c && cnt_c == CW'(W)));
  p_value_r3_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> result == exp_q);
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(result)));
endmodule

bind serial_addsub serial_addsub_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .sub_mode(sub_mode),
  .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result), .done(done)
);

// File: tb/serial_addsub_tb.sv
module serial_addsub_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       sub_mode = 1'b0;
  logic [3:0] opnd_a = '0;
  logic [3:0] opnd_b = '0;
  logic [3:0] result;
  logic       done;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  serial_addsub #(.W(4)) u_dut (
    .clk(clk), .rst(rst), .start(start), .sub_mode(sub_mode),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result), .done(done)
  );

  function automatic logic [3:0] ref_val(logic [3:0] a, logic [3:0] b, logic m);
    logic [4:0] t;
    t = m ? {1'b0, a} + {1'b0, ~b} + 5'd1 : {1'b0, a} + {1'b0, b};
    return t[3:0];
  endfunction

  function automatic logic [3:0] partial(logic [3:0] a, logic [3:0] f, int k);
    logic [7:0] t;
    t = ({4'b0, a} >> k) | ({4'b0, f} << (4 - k));
    return t[3:0];
  endfunction

  task automatic check(string req, logic [4:0] act, logic [4:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic load(logic [3:0] a, logic [3:0] b, logic m);
    opnd_a = a; opnd_b = b; sub_mode = m; start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    opnd_a = 4'($urandom); opnd_b = 4'($urandom); sub_mode = 1'($urandom);
    check("R2 load", {done, result}, {1'b0, a});
  endtask

  task automatic run_op(logic [3:0] a, logic [3:0] b, logic m);
    logic [3:0] f;
    f = ref_val(a, b, m);
    load(a, b, m);
    for (int k = 1; k <= 4; k++) begin
      @(posedge clk); @(negedge clk);
      opnd_a = 4'($urandom); opnd_b = 4'($urandom); sub_mode = 1'($urandom);
      check("R8 partial", {1'b0, result}, {1'b0, partial(a, f, k)});
      check("R5 done", {4'b0, done}, {4'b0, (k == 4)});
    end
    check(m ? "R4 sub" : "R3 add", {done, result}, {1'b1, f});
    for (int j = 0; j < 3; j++) begin
      @(posedge clk); @(negedge clk);
      opnd_a = 4'($urandom); opnd_b = 4'($urandom); sub_mode = 1'($urandom);
    end
    check("R6 hold", {done, result}, {1'b1, f});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset", {done, result}, 5'd0);
    run_op(4'd2, 4'd3, 1'b0);
    run_op(4'd3, 4'd1, 1'b0);
    run_op(4'd3, 4'd1, 1'b1);
    run_op(4'd15, 4'd1, 1'b0);
    check("R9 wrap add", {1'b0, result}, 5'd0);
    run_op(4'd0, 4'd1, 1'b1);
    check("R9 wrap sub", {1'b0, result}, 5'd15);
    run_op(4'd9, 4'd9, 1'b1);
    // R7: restart mid-run
    load(4'd7, 4'd6, 1'b0);
    repeat (2) begin @(posedge clk); @(negedge clk); end
    run_op(4'd5, 4'd12, 1'b1);
    check("R7 restart", {done, result}, {1'b1, 4'd9});
    // R1: reset mid-run
    load(4'd6, 4'd5, 1'b0);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    check("R1 reset mid-run", {done, result}, 5'd0);
    for (int i = 0; i < 300; i++)
      run_op(4'($urandom), 4'($urandom), 1'($urandom));
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule